// File: doc/BRIEF.md
# Two-Channel Tone Qualifier Output Stage

This block turns a per-channel tone-present flag, produced by an upstream frequency detector, into the channel's digital output. All channels share one mode input. In follower mode each output copies its flag, so the output is high for as long as the detector reports a valid decode. In packet mode the output changes only after tone, or the absence of tone, has built up for a set time. Each channel has an up/down integrator that is clocked by a slow tick. The integrator counts up on ticks where tone is present and down on ticks where it is absent, and it saturates at both ends. Short dropouts therefore only drain the count slightly and do not clear the output.

A shared high-impedance request releases every output. The block presents each pin as a data bit and a drive enable, which a pad cell or the top level turns into a three-state pin. With a 3.579545 MHz clock, the default divide of 3580 gives a tick of about 1 ms. The default bound of 44 ticks places response and de-response between 40 ms and 48 ms. Every output is registered, so a change of mode or of the high-impedance request reaches the pins one clock later, well under 500 ns.

Top module: `tone_qual_out`

## Requirements
- R1: While reset is high and in the first cycle after it, every integrator is empty, every packet flag is clear, and ch_data and ch_drive are 0.
- R2: The integration tick fires once every TICK_DIV clock cycles. Integrators change only on a tick.
- R3: With follow_sel=1 and out_hiz=0, ch_data[i] equals tone_i[i] from the previous clock edge.
- R4: In packet mode (follow_sel=0), a channel whose integrator starts empty drives ch_data high on the cycle after the tick that brings its integrator to INTEG_MAX. It stays low before that tick.
- R5: In packet mode, a set output clears on the cycle after the tick that drains its integrator to 0.
- R6: The integrator saturates at INTEG_MAX and at 0. Tone beyond INTEG_MAX ticks does not lengthen the later de-response, and silence at 0 does not delay a later response.
- R7: In packet mode, a no-tone dropout shorter than INTEG_MAX ticks, inside a tone burst, leaves a set output high.
- R8: out_hiz=1 makes ch_drive all zeros and ch_data all zeros on the next cycle. out_hiz=0 makes ch_drive all ones on the next cycle.
- R9: Each channel integrates only its own tone_i bit.
- R10: A change of follow_sel takes effect on the next cycle. The integrators keep running in follower mode, so packet state carries across mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tone_i | input | NUM_CH | Tone-present flag per channel |
| follow_sel | input | 1 | 1 selects follower mode, 0 selects packet mode |
| out_hiz | input | 1 | 1 releases every output (high impedance) |
| ch_data | output | NUM_CH | Registered output value per channel |
| ch_drive | output | NUM_CH | Pad drive enable per channel; 0 means high impedance |

## Verification
The assertions check on every cycle the properties that are local to one piece of logic:
- the spacing of ticks;
- the integrator's bounds and its stillness between ticks;
- agreement between the packet flag and the integrator at empty and full;
- the one-cycle follower path;
- release under the high-impedance request.

Only the bench's scenarios can show the timing that builds up over many ticks. These are:
- the exact response and de-response instants;
- the effect of saturation on later timing;
- ride-through of dropouts;
- independence of the channels;
- packet state carried across mode changes.

The bench checks these against a behavioural reference model on every clock.

// File: rtl/tq_pkg.sv
package tq_pkg;
  typedef enum logic {
    MODE_PACKET = 1'b0,
    MODE_FOLLOW = 1'b1
  } out_mode_e;
endpackage

// File: rtl/tq_tick_gen.sv
module tq_tick_gen #(
  parameter int TICK_DIV = 3580
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
      tick <= (cnt == LAST);
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);

  generate
    if (TICK_DIV > 1) begin : g_spacing
      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/tq_integrator.sv
module tq_integrator #(
  parameter int INTEG_MAX = 44
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic tone,
  output logic pkt
);
  localparam int LW = $clog2(INTEG_MAX + 1);
  localparam logic [LW-1:0] FULL = LW'(INTEG_MAX);

  logic [LW-1:0] lvl;
  logic [LW-1:0] lvl_nxt;

  always_comb begin
    lvl_nxt = lvl;
    if (tick) begin
      if (tone && lvl != FULL)      lvl_nxt = lvl + 1'b1;
      else if (!tone && lvl != '0)  lvl_nxt = lvl - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= '0;
      pkt <= 1'b0;
    end else begin
      lvl <= lvl_nxt;
      if (lvl_nxt == FULL)    pkt <= 1'b1;
      else if (lvl_nxt == '0) pkt <= 1'b0;
    end
  end

  // R6
  lvl_bound_chk: assert property (@(posedge clk) disable iff (rst) lvl <= FULL);
  // R2
  lvl_still_chk: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(lvl));
  // R5
  empty_clear_chk: assert property (@(posedge clk) disable iff (rst) (lvl == '0) |-> !pkt);
  // R4
  full_set_chk: assert property (@(posedge clk) disable iff (rst) (lvl == FULL) |-> pkt);
endmodule

// File: rtl/tq_out_stage.sv
module tq_out_stage
  import tq_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  out_mode_e         mode,
  input  logic              out_hiz,
  input  logic [NUM_CH-1:0] tone,
  input  logic [NUM_CH-1:0] pkt,
  output logic [NUM_CH-1:0] ch_data,
  output logic [NUM_CH-1:0] ch_drive
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ch_data  <= '0;
      ch_drive <= '0;
    end else begin
      ch_drive <= out_hiz ? '0 : '1;
      if (out_hiz)                  ch_data <= '0;
      else if (mode == MODE_FOLLOW) ch_data <= tone;
      else                          ch_data <= pkt;
    end
  end

  // R8
  hiz_release_chk: assert property (@(posedge clk) disable iff (rst)
    out_hiz |=> (ch_drive == '0 && ch_data == '0));
  // R8
  drive_on_chk: assert property (@(posedge clk) disable iff (rst)
    !out_hiz |=> (ch_drive == '1));
  // R3
  follow_path_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FOLLOW && !out_hiz) |=> (ch_data == $past(tone)));
endmodule

// File: rtl/tone_qual_out.sv
module tone_qual_out
  import tq_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int TICK_DIV  = 3580,
  parameter int INTEG_MAX = 44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] tone_i,
  input  logic              follow_sel,
  input  logic              out_hiz,
  output logic [NUM_CH-1:0] ch_data,
  output logic [NUM_CH-1:0] ch_drive
);
  logic              tick;
  logic [NUM_CH-1:0] pkt;
  out_mode_e         mode;

  assign mode = follow_sel ? MODE_FOLLOW : MODE_PACKET;

  tq_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      tq_integrator #(.INTEG_MAX(INTEG_MAX)) u_integ (
        .clk (clk),
        .rst (rst),
        .tick(tick),
        .tone(tone_i[g]),
        .pkt (pkt[g])
      );
    end
  endgenerate

  tq_out_stage #(.NUM_CH(NUM_CH)) u_out (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .out_hiz (out_hiz),
    .tone    (tone_i),
    .pkt     (pkt),
    .ch_data (ch_data),
    .ch_drive(ch_drive)
  );
endmodule

// File: tb/tb_tone_qual_out.sv
module tb_tone_qual_out;
  localparam int NCH = 2;
  localparam int DIV = 4;
  localparam int MX  = 5;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] tone_i = '0;
  logic           follow_sel = 1'b0;
  logic           out_hiz = 1'b0;
  logic [NCH-1:0] ch_data;
  logic [NCH-1:0] ch_drive;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    started = 0;

  // reference model state
  int m_cnt = 0;
  bit m_tick = 0;
  int m_lvl[NCH];
  bit m_pkt[NCH];
  bit m_data[NCH];
  bit m_drv[NCH];

  always #2 clk = ~clk;

  tone_qual_out #(.NUM_CH(NCH), .TICK_DIV(DIV), .INTEG_MAX(MX)) dut (
    .clk(clk), .rst(rst), .tone_i(tone_i), .follow_sel(follow_sel),
    .out_hiz(out_hiz), .ch_data(ch_data), .ch_drive(ch_drive)
  );

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_cnt = 0; m_tick = 0;
      for (int i = 0; i < NCH; i++) begin
        m_lvl[i] = 0; m_pkt[i] = 0; m_data[i] = 0; m_drv[i] = 0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        m_drv[i]  = !out_hiz;
        m_data[i] = out_hiz ? 1'b0 : (follow_sel ? tone_i[i] : m_pkt[i]);
        if (m_tick) begin
          if (tone_i[i]) m_lvl[i] = (m_lvl[i] < MX) ? m_lvl[i] + 1 : MX;
          else           m_lvl[i] = (m_lvl[i] > 0) ? m_lvl[i] - 1 : 0;
        end
        if (m_lvl[i] == MX)     m_pkt[i] = 1;
        else if (m_lvl[i] == 0) m_pkt[i] = 0;
      end
      m_tick = (m_cnt == DIV - 1);
      m_cnt  = (m_cnt + 1) % DIV;
    end
  end

  task automatic check_bit(string what, int ch, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s ch%0d: actual=%0b expected=%0b at %0t", tag, what, ch, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      for (int i = 0; i < NCH; i++) begin
        check_bit("data", i, ch_data[i], m_data[i]);
        check_bit("drive", i, ch_drive[i], m_drv[i]);
      end
    end
  end

  task automatic run(input logic [NCH-1:0] t, input bit f, input bit h, input int n);
    tone_i = t; follow_sel = f; out_hiz = h;
    repeat (n) @(negedge clk);
  endtask

  // explicit point check: ch0 value now
  task automatic expect_now(string req, int ch, bit exp);
    tag = req;
    check_bit("point", ch, ch_data[ch], exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_now("R1", 0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    tag = "R1";
    // R3: follower pattern
    tag = "R3";
    run(2'b01, 1, 0, 3); run(2'b10, 1, 0, 2); run(2'b11, 1, 0, 1); run(2'b00, 1, 0, 2);
    // R2/R4: packet response after MX ticks, both channels
    tag = "R4";
    run(2'b11, 0, 0, MX * DIV - 2);
    expect_now("R4", 0, 1'b0);
    run(2'b11, 0, 0, 4);
    expect_now("R4", 0, 1'b1);
    // R6: saturate then count de-response
    tag = "R6";
    run(2'b11, 0, 0, 6 * DIV);
    // R7: dropout ride-through
    tag = "R7";
    run(2'b00, 0, 0, 2 * DIV);
    run(2'b11, 0, 0, 2 * DIV);
    expect_now("R7", 0, 1'b1);
    // R5: drain to zero
    tag = "R5";
    run(2'b00, 0, 0, (MX + 2) * DIV + 2);
    expect_now("R5", 0, 1'b0);
    // R9: independent channels
    tag = "R9";
    run(2'b10, 0, 0, (MX + 2) * DIV);
    expect_now("R9", 0, 1'b0);
    expect_now("R9", 1, 1'b1);
    // R10: follower mode while integrating, then back to packet
    tag = "R10";
    run(2'b01, 1, 0, 3 * DIV);
    run(2'b01, 0, 0, 3 * DIV);
    // R8: high impedance in both modes
    tag = "R8";
    run(2'b11, 1, 1, 5); run(2'b11, 0, 1, 5); run(2'b01, 0, 0, 3);
    // R1: reset mid-run
    tag = "R1";
    rst = 1'b1; run(2'b11, 0, 0, 3);
    rst = 1'b0; run(2'b00, 0, 0, 3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule